// File: doc/BRIEF.md
# Per-Pin Functional Test Vector Sequencer

This block applies a single functional test vector to a device under test and reports whether the device answered correctly. The vector arrives as one 4-bit condition code per vector position. A small pin-map table routes each position to a physical pin. For every pin the block drives a value and an enable. It also controls one weak pull direction that is shared by all pins, and it samples the pin levels coming back.

A run is a fixed series of timed phases. First the steady levels are applied and left to settle. Next the pins that carry a clock-style pulse are toggled, and the block waits to settle again. Finally every pin is observed twice: once with the weak pull set high and once with it set low. When the run ends, the block registers a per-pin fail mask, a pass flag and an error flag, and it marks the result with a one-cycle done pulse. Settle time and pulse width are programmable cycle counts.

Top module: `tvs_seq`

## Requirements
- R1: After reset the block is idle, busy, done, pass, err, pull_hi, pin_oe, pin_drv and fail_mask are all 0, and the pin map is the identity: position i goes to pin index i.
- R2: Code 0 drives its pin low and code 1 drives it high, with the enable held on for every cycle from the first settle phase through the pull-low probe phase.
- R3: Code 2 holds the pin low during the first settle phase, drives it high for the pulse phase, then low again. Code 3 is the inverse: high, low for the pulse phase, then high.
- R4: Code 8 drives the default level that dflt_lvl had when the vector was started.
- R5: Code 7 (untested) and code 9 (float) leave the pin undriven, and such a pin never sets a fail-mask bit, whatever level it shows.
- R6: Code 4 expects high and code 5 expects low. The fail-mask bit of a pin is set when the pin does not read the expected level in both probe phases. pass is 1 only when the mask is all zero and err is 0.
- R7: Code 6 expects high impedance. The pin passes only if it reads 1 while pulled high and 0 while pulled low. A pin driven by the device fails.
- R8: Output sampling happens only after the pulse phase and the settle that follows it. pull_hi is 1 for exactly one settle period starting 2*S+P cycles into the run, and 0 at all other times.
- R9: A map write with map_we sends vector position map_pos to physical pin map_pin for all vectors that start later.
- R10: Any code from 10 to 15 marks the vector as errored: err=1, pass=0, fail_mask=0, no pin is driven, and busy lasts one cycle.
- R11: start is taken only while idle, so a start during a run is ignored. done is a one-cycle pulse, and the results hold until the next done.
- R12: With S = max(settle_cyc,1) and P = max(pulse_cyc,1), a valid vector keeps busy high for exactly 4*S+P+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a vector (taken when idle) |
| cond_vec | input | NPIN*4 | Condition code per vector position, position p at bits [4p+3:4p] |
| dflt_lvl | input | 1 | Level driven by code 8 |
| settle_cyc | input | CNT_W | Settle phase length in cycles (0 acts as 1) |
| pulse_cyc | input | CNT_W | Pulse phase length in cycles (0 acts as 1) |
| map_we | input | 1 | Pin-map write strobe |
| map_pos | input | IDX_W | Vector position to remap |
| map_pin | input | IDX_W | Physical pin index for that position |
| pin_in | input | NPIN | Sampled pin levels |
| pin_drv | output | NPIN | Per-pin drive value |
| pin_oe | output | NPIN | Per-pin drive enable |
| pull_hi | output | 1 | Weak pull direction, 1 = up, 0 = down |
| busy | output | 1 | Vector in progress |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Vector passed |
| err | output | 1 | Vector held an unsupported code |
| fail_mask | output | NPIN | Per-physical-pin failures |

## Verification
The properties rely on these input assumptions:
- pin_in is synchronous to clk and is steady by the last cycle of each probe phase.
- The pin map holds a permutation.
- settle_cyc and pulse_cyc do not change while busy is high.

The stimulus keeps to these assumptions. The modelled device pins are combinational functions of the block's own registered drives and pull, plus one flop clocked by a pulsed pin. Map entries are only written as swaps, which are undone afterwards. Timing inputs and dflt_lvl change only between runs.

// File: rtl/tvs_pkg.sv
package tvs_pkg;
  localparam int CODE_W = 4;

  localparam logic [CODE_W-1:0] C_LO    = 4'd0;
  localparam logic [CODE_W-1:0] C_HI    = 4'd1;
  localparam logic [CODE_W-1:0] C_PLH   = 4'd2;
  localparam logic [CODE_W-1:0] C_PHL   = 4'd3;
  localparam logic [CODE_W-1:0] C_EXPH  = 4'd4;
  localparam logic [CODE_W-1:0] C_EXPL  = 4'd5;
  localparam logic [CODE_W-1:0] C_EXPZ  = 4'd6;
  localparam logic [CODE_W-1:0] C_SKIP  = 4'd7;
  localparam logic [CODE_W-1:0] C_DFLT  = 4'd8;
  localparam logic [CODE_W-1:0] C_FLOAT = 4'd9;

  typedef enum logic [2:0] {
    ST_IDLE, ST_APPLY, ST_PULSE, ST_RECOV, ST_PUP, ST_PDN, ST_FIN
  } phase_e;
endpackage

// File: rtl/tvs_pinmap.sv
module tvs_pinmap
  import tvs_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int IDX_W = $clog2(NPIN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       pos,
  input  logic [IDX_W-1:0]       pin,
  input  logic [NPIN*CODE_W-1:0] pos_codes,
  output logic [NPIN*CODE_W-1:0] pin_codes
);
  logic [IDX_W-1:0] tbl [NPIN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPIN; i++) tbl[i] <= IDX_W'(i);
    end else if (we && (int'(pos) < NPIN)) begin
      tbl[pos] <= pin;
    end
  end

  always_comb begin
    pin_codes = {NPIN{C_SKIP}};
    for (int q = 0; q < NPIN; q++) begin
      for (int p = 0; p < NPIN; p++) begin
        if (tbl[p] == IDX_W'(q)) pin_codes[q*CODE_W +: CODE_W] = pos_codes[p*CODE_W +: CODE_W];
      end
    end
  end
endmodule

// File: rtl/tvs_timer.sv
module tvs_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (len == '0) ? '0 : len - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/tvs_pindrv.sv
module tvs_pindrv
  import tvs_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic [NPIN*CODE_W-1:0] codes,
  input  logic                   dflt,
  input  logic                   active,
  input  logic                   pulse_on,
  output logic [NPIN-1:0]        oe,
  output logic [NPIN-1:0]        val
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [CODE_W-1:0] c;
    assign c = codes[g*CODE_W +: CODE_W];
    always_comb begin
      oe[g]  = 1'b0;
      val[g] = 1'b0;
      if (active) begin
        case (c)
          C_LO:   begin oe[g] = 1'b1; val[g] = 1'b0;      end
          C_HI:   begin oe[g] = 1'b1; val[g] = 1'b1;      end
          C_PLH:  begin oe[g] = 1'b1; val[g] = pulse_on;  end
          C_PHL:  begin oe[g] = 1'b1; val[g] = !pulse_on; end
          C_DFLT: begin oe[g] = 1'b1; val[g] = dflt;      end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tvs_judge.sv
module tvs_judge
  import tvs_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic [NPIN*CODE_W-1:0] codes,
  input  logic [NPIN-1:0]        s_up,
  input  logic [NPIN-1:0]        s_dn,
  output logic [NPIN-1:0]        fail
);
  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [CODE_W-1:0] c;
    assign c = codes[g*CODE_W +: CODE_W];
    always_comb begin
      case (c)
        C_EXPH:  fail[g] = !(s_up[g] && s_dn[g]);
        C_EXPL:  fail[g] = s_up[g] || s_dn[g];
        C_EXPZ:  fail[g] = !(s_up[g] && !s_dn[g]);
        default: fail[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/tvs_seq.sv
module tvs_seq
  import tvs_pkg::*;
#(
  parameter int NPIN  = 8,
  parameter int CNT_W = 8,
  parameter int IDX_W = $clog2(NPIN)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [NPIN*CODE_W-1:0] cond_vec,
  input  logic                   dflt_lvl,
  input  logic [CNT_W-1:0]       settle_cyc,
  input  logic [CNT_W-1:0]       pulse_cyc,
  input  logic                   map_we,
  input  logic [IDX_W-1:0]       map_pos,
  input  logic [IDX_W-1:0]       map_pin,
  input  logic [NPIN-1:0]        pin_in,
  output logic [NPIN-1:0]        pin_drv,
  output logic [NPIN-1:0]        pin_oe,
  output logic                   pull_hi,
  output logic                   busy,
  output logic                   done,
  output logic                   pass,
  output logic                   err,
  output logic [NPIN-1:0]        fail_mask
);
  localparam int VEC_W = NPIN * CODE_W;

  phase_e            state_q, state_d;
  logic [VEC_W-1:0]  mapped, codes_q, codes_d;
  logic              dflt_q, dflt_d, bad_q, any_bad, accept, expire, tload;
  logic [CNT_W-1:0]  tlen;
  logic [NPIN-1:0]   oe_c, val_c, fail_c, s_up_q, s_dn_q;
  logic              active_d;

  tvs_pinmap #(.NPIN(NPIN), .IDX_W(IDX_W)) i_map (
    .clk(clk), .rst(rst), .we(map_we), .pos(map_pos), .pin(map_pin),
    .pos_codes(cond_vec), .pin_codes(mapped)
  );

  always_comb begin
    any_bad = 1'b0;
    for (int p = 0; p < NPIN; p++) begin
      if (cond_vec[p*CODE_W +: CODE_W] > C_FLOAT) any_bad = 1'b1;
    end
  end

  assign accept  = start && (state_q == ST_IDLE);
  assign codes_d = accept ? mapped : codes_q;
  assign dflt_d  = accept ? dflt_lvl : dflt_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept) state_d = any_bad ? ST_FIN : ST_APPLY;
      ST_APPLY: if (expire) state_d = ST_PULSE;
      ST_PULSE: if (expire) state_d = ST_RECOV;
      ST_RECOV: if (expire) state_d = ST_PUP;
      ST_PUP:   if (expire) state_d = ST_PDN;
      ST_PDN:   if (expire) state_d = ST_FIN;
      ST_FIN:   if (expire) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign tload = (state_d != state_q);
  assign tlen  = (state_d == ST_PULSE) ? pulse_cyc :
                 (state_d == ST_FIN)   ? CNT_W'(1) : settle_cyc;

  tvs_timer #(.CNT_W(CNT_W)) i_tmr (
    .clk(clk), .rst(rst), .load(tload), .len(tlen), .expire(expire)
  );

  assign active_d = (state_d == ST_APPLY) || (state_d == ST_PULSE) || (state_d == ST_RECOV) ||
                    (state_d == ST_PUP)   || (state_d == ST_PDN);

  tvs_pindrv #(.NPIN(NPIN)) i_drv (
    .codes(codes_d), .dflt(dflt_d), .active(active_d),
    .pulse_on(state_d == ST_PULSE), .oe(oe_c), .val(val_c)
  );

  tvs_judge #(.NPIN(NPIN)) i_jdg (
    .codes(codes_q), .s_up(s_up_q), .s_dn(s_dn_q), .fail(fail_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      codes_q   <= {NPIN{C_SKIP}};
      dflt_q    <= 1'b0;
      bad_q     <= 1'b0;
      pin_oe    <= '0;
      pin_drv   <= '0;
      pull_hi   <= 1'b0;
      s_up_q    <= '0;
      s_dn_q    <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      err       <= 1'b0;
      fail_mask <= '0;
    end else begin
      state_q <= state_d;
      codes_q <= codes_d;
      dflt_q  <= dflt_d;
      if (accept) bad_q <= any_bad;
      pin_oe  <= oe_c;
      pin_drv <= val_c;
      pull_hi <= (state_d == ST_PUP);
      if (state_q == ST_PUP && expire) s_up_q <= pin_in;
      if (state_q == ST_PDN && expire) s_dn_q <= pin_in;
      done <= 1'b0;
      if (state_q == ST_FIN && expire) begin
        done      <= 1'b1;
        err       <= bad_q;
        fail_mask <= bad_q ? '0 : fail_c;
        pass      <= !bad_q && (fail_c == '0);
      end
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/tvs_seq_chk.sv
module tvs_seq_chk #(
  parameter int NPIN = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            pass,
  input logic            err,
  input logic            pull_hi,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] fail_mask
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (pin_oe == '0)); // R1
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
    pass |-> (fail_mask == '0 && !err)); // R6
  AST_PULL_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    pull_hi |-> busy); // R8
  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> (!pass && fail_mask == '0 && $past(pin_oe) == '0)); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11
  AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R11
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (!done && $past(!done)) |-> ($stable(pass) && $stable(err))); // R11
endmodule

bind tvs_seq tvs_seq_chk #(.NPIN(NPIN)) i_tvs_seq_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .pass(pass),
  .err(err), .pull_hi(pull_hi), .pin_oe(pin_oe), .fail_mask(fail_mask)
);

// File: tb/test_tvs_seq.sv
module test_tvs_seq;
  localparam int NPIN = 8;
  localparam int CNT_W = 8;
  localparam int IDX_W = 3;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NPIN*4-1:0] cond_vec = {NPIN{4'd7}};
  logic dflt_lvl = 1'b0;
  logic [CNT_W-1:0] settle_cyc = 8'd3, pulse_cyc = 8'd2;
  logic map_we = 1'b0;
  logic [IDX_W-1:0] map_pos = '0, map_pin = '0;
  logic [NPIN-1:0] pin_in, pin_drv, pin_oe, fail_mask;
  logic pull_hi, busy, done, pass, err;

  logic [NPIN-1:0] dev_en = '0, dev_val = '0;
  logic use_ff = 1'b0, ff_clr = 1'b1, ff_q;
  logic [NPIN-1:0] dev_eff;

  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  logic [NPIN-1:0] tr_oe [128];
  logic [NPIN-1:0] tr_drv [128];
  logic tr_pull [128];
  logic tr_busy [128];
  int ntr;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge pin_drv[0] or posedge ff_clr) begin
    if (ff_clr) ff_q <= 1'b0;
    else ff_q <= 1'b1;
  end

  always_comb begin
    dev_eff = dev_val;
    if (use_ff) dev_eff[6] = ff_q;
  end
  assign pin_in = (pin_oe & pin_drv) | (~pin_oe & dev_en & dev_eff) | (~pin_oe & ~dev_en & {NPIN{pull_hi}});

  tvs_seq #(.NPIN(NPIN), .CNT_W(CNT_W)) i_tvs_seq (
    .clk(clk), .rst(rst), .start(start), .cond_vec(cond_vec), .dflt_lvl(dflt_lvl),
    .settle_cyc(settle_cyc), .pulse_cyc(pulse_cyc), .map_we(map_we), .map_pos(map_pos),
    .map_pin(map_pin), .pin_in(pin_in), .pin_drv(pin_drv), .pin_oe(pin_oe),
    .pull_hi(pull_hi), .busy(busy), .done(done), .pass(pass), .err(err), .fail_mask(fail_mask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setc(input int pos, input logic [3:0] c);
    cond_vec[pos*4 +: 4] = c;
  endtask

  task automatic clear_codes();
    cond_vec = {NPIN{4'd7}};
    dev_en = '0; dev_val = '0; use_ff = 1'b0;
  endtask

  // start a vector, trace outputs each cycle until done; restart = index at which start is pulsed again
  task automatic run_vec(input int restart);
    @(negedge clk); start = 1'b1;
    ntr = 0;
    for (int k = 0; k < 120; k++) begin
      @(negedge clk);
      start = (k == restart);
      tr_oe[k] = pin_oe; tr_drv[k] = pin_drv; tr_pull[k] = pull_hi; tr_busy[k] = busy;
      ntr = k;
      if (done) break;
    end
    start = 1'b0;
  endtask

  function automatic int busy_count();
    int n = 0;
    for (int k = 0; k <= ntr; k++) if (tr_busy[k]) n++;
    return n;
  endfunction

  task automatic t_reset();
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 pass", pass, 0);
    chk("R1 err", err, 0); chk("R1 pull", pull_hi, 0); chk("R1 oe", pin_oe, 0);
    chk("R1 drv", pin_drv, 0); chk("R1 fail", fail_mask, 0);
  endtask

  task automatic t_steady();
    int bad;
    int len;
    clear_codes();
    setc(0, 4'd0); setc(1, 4'd1); setc(2, 4'd8); setc(3, 4'd9); setc(4, 4'd7); setc(5, 4'd8);
    dev_en = 8'b0001_1000; dev_val = 8'b0000_1000;
    dflt_lvl = 1'b1;
    run_vec(-1);
    len = 4*3 + 2;
    bad = 0;
    for (int k = 0; k < len; k++) if (tr_oe[k] !== 8'h27 || tr_drv[k] !== 8'h26) bad++;
    chk("R2 R4 steady drive cycles wrong", bad, 0);
    chk("R5 float/skip pins undriven at end", tr_oe[len], 0);
    chk("R5 fail mask", fail_mask, 0);
    chk("R2 pass", pass, 1);
    dflt_lvl = 1'b0;
    run_vec(-1);
    bad = 0;
    for (int k = 0; k < len; k++) if (tr_drv[k] !== 8'h02 || tr_oe[k] !== 8'h27) bad++;
    chk("R4 default low cycles wrong", bad, 0);
  endtask

  task automatic t_pulse();
    int bad;
    int s;
    int p;
    clear_codes();
    setc(0, 4'd2); setc(1, 4'd3);
    for (int r = 0; r < 2; r++) begin
      settle_cyc = (r == 0) ? 8'd3 : 8'd0;
      pulse_cyc  = (r == 0) ? 8'd2 : 8'd0;
      s = (r == 0) ? 3 : 1;
      p = (r == 0) ? 2 : 1;
      run_vec(-1);
      bad = 0;
      for (int k = 0; k < 4*s+p; k++) begin
        logic hi;
        hi = (k >= s) && (k < s+p);
        if (tr_oe[k][1:0] !== 2'b11 || tr_drv[k][0] !== hi || tr_drv[k][1] !== !hi) bad++;
      end
      chk("R3 pulse shape mismatching cycles", bad, 0);
      chk("R12 busy length", busy_count(), 4*s+p+1);
    end
    settle_cyc = 8'd3; pulse_cyc = 8'd2;
  endtask

  task automatic t_compare();
    int bad;
    clear_codes();
    setc(0, 4'd2); setc(5, 4'd4); setc(6, 4'd4); setc(7, 4'd5);
    dev_en = 8'b1110_0000; dev_val = 8'b0010_0000; use_ff = 1'b1;
    ff_clr = 1'b1; #1 ff_clr = 1'b0;
    run_vec(-1);
    chk("R8 registered pin seen only after pulse", fail_mask, 0);
    chk("R6 pass all ok", pass, 1);
    bad = 0;
    for (int k = 0; k <= ntr; k++) if (tr_pull[k] !== (k >= 8 && k < 11)) bad++;
    chk("R8 pull-up window", bad, 0);
    dev_val = 8'b1000_0000;
    ff_clr = 1'b1; #1 ff_clr = 1'b0;
    run_vec(-1);
    chk("R6 wrong levels flagged", fail_mask, 8'hA0);
    chk("R6 pass low on failure", pass, 0);
  endtask

  task automatic t_hiz();
    clear_codes();
    setc(2, 4'd6); setc(3, 4'd6); setc(4, 4'd6);
    dev_en = 8'b0001_1000; dev_val = 8'b0000_1000;
    run_vec(-1);
    chk("R7 driven pins fail high-z", fail_mask, 8'h18);
    dev_en = '0;
    run_vec(-1);
    chk("R7 floating pins pass", pass, 1);
  endtask

  task automatic wr_map(input int pos, input int pin);
    @(negedge clk); map_we = 1'b1; map_pos = IDX_W'(pos); map_pin = IDX_W'(pin);
    @(negedge clk); map_we = 1'b0;
  endtask

  task automatic t_map();
    clear_codes();
    setc(0, 4'd1); setc(3, 4'd0);
    run_vec(-1);
    chk("R9 identity oe", tr_oe[0], 8'h09);
    chk("R9 identity drv", tr_drv[0], 8'h01);
    wr_map(0, 3); wr_map(3, 0);
    run_vec(-1);
    chk("R9 swapped drv", tr_drv[0], 8'h08);
    chk("R9 swapped oe", tr_oe[0], 8'h09);
    wr_map(0, 0); wr_map(3, 3);
  endtask

  task automatic t_error();
    int bad;
    clear_codes();
    for (int i = 0; i < NPIN; i++) setc(i, 4'd1);
    setc(4, 4'd12);
    run_vec(-1);
    bad = 0;
    for (int k = 0; k <= ntr; k++) if (tr_oe[k] !== 8'h00) bad++;
    chk("R10 no drive cycles", bad, 0);
    chk("R10 err", err, 1); chk("R10 pass", pass, 0); chk("R10 fail", fail_mask, 0);
    chk("R10 busy length", busy_count(), 1);
    setc(4, 4'd15);
    run_vec(-1);
    chk("R10 code 15 err", err, 1);
  endtask

  task automatic t_restart();
    int extra;
    clear_codes();
    setc(0, 4'd1);
    run_vec(2);
    chk("R11 ignored start keeps length", busy_count(), 15);
    chk("R11 pass after run", pass, 1);
    extra = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || busy) extra++;
    end
    chk("R11 no second run or done", extra, 0);
    chk("R11 result held", pass, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_steady();
    t_pulse();
    t_compare();
    t_hiz();
    t_map();
    t_error();
    t_restart();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule